// File: doc/BRIEF.md
# Gated AXI Write Congestion Source

This block is a write-only AXI master that loads a memory port with synthetic traffic. Once enabled it issues incrementing write bursts, one at a time, into a fixed address window. Each burst runs through the address, data and response phases. A fixed number of quiet cycles then follows before the next burst starts. This lets the source take a large share of memory bandwidth without holding the port continuously. The payload is a counting pattern, so a waveform shows which burst and which beat each data word belongs to.

Two pulse inputs control the traffic. A start pulse arms the generator and a stop pulse disarms it. The burst lengths follow a repeating four-step pattern of minimum, maximum, minimum and a filler length. The filler is chosen so that the mean length is exactly the programmed average. Addresses advance contiguously through the window and return to the window base whenever the next burst would not fit. Stopping never cuts a burst short. After a stop and a later start, the generator resumes at the next length and address in its sequence.

Top module: `axi_wr_traffic_gen`

## Requirements
- R1: While reset is asserted, and after it until a start pulse arrives, awvalid, wvalid and bready are low and busy_o is low.
- R2: A one-cycle start pulse sampled at clock edge N makes awvalid high from edge N+2 on. Without a start pulse no address is ever issued.
- R3: Burst lengths in beats repeat the order 4, 16, 4, 8 (mean 8), counted from reset. awlen carries beats minus one, awsize is 3 (8-byte beats) and awburst is 1 (incrementing).
- R4: The first burst after reset starts at the window base. Each following burst starts at the previous start plus beats times 8. If that burst would end past base plus window size, it starts at the base instead, so no byte written lies outside the window.
- R5: Each burst carries exactly awlen+1 data beats, and wlast is high on the final beat only. The upper half of wdata is the burst number since reset, the lower half is the beat index from 0, and wstrb is all ones.
- R6: Data beats start only after the address handshake. bready is high only after the last beat has been accepted. No new address is issued before the previous burst's response handshake.
- R7: Between a response handshake and the next awvalid, exactly 5 cycles pass with no channel valid.
- R8: A stop pulse lets the burst in progress finish through its response and the gap, after which the block idles with busy_o low. A later start resumes the length and address sequence where it left off.
- R9: If start and stop arrive in the same cycle, stop wins and the block does not start.
- R10: Once asserted, awvalid and wvalid stay high with stable address, length, data and wlast until their handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Pulse that arms traffic generation |
| stop_i | input | 1 | Pulse that disarms traffic generation, priority over start |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type, incrementing |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | DATA_W | Pattern payload |
| m_wstrb | output | DATA_W/8 | Byte enables, all set |
| m_wlast | output | 1 | Final beat of the burst |
| m_wvalid | output | 1 | Data valid |
| m_wready | input | 1 | Data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Response ready |
| busy_o | output | 1 | High while a burst or its gap is in progress |

## Verification
The hardest case to reach is the wrap to the window base. It only happens after several bursts of different lengths have filled the window up to a point where the long burst no longer fits. The bench therefore shrinks the window to 320 bytes, so that a 16-beat burst wraps on the sixth and again on the tenth burst. It also varies the address delays, data stalls and response delays from burst to burst. A stop is sent in the middle of the tenth burst, and the following restart must continue from the remembered phase and address rather than from the base.

// File: rtl/wtg_pkg.sv
package wtg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP,
    ST_GAP
  } wtg_state_e;
endpackage

// File: rtl/wtg_len_seq.sv
// Four-phase burst length sequencer: min, max, min, filler.
module wtg_len_seq #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 16,
  parameter int AVG_LEN = 8,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int FILL_LEN = 4*AVG_LEN - MAX_LEN - 2*MIN_LEN;

  logic [1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (advance_i) ph_d = ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    case (ph_q)
      2'd0, 2'd2: len_o = LEN_W'(MIN_LEN);
      2'd1:       len_o = LEN_W'(MAX_LEN);
      default:    len_o = LEN_W'(FILL_LEN);
    endcase
  end

  a_r3_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (len_o >= LEN_W'(MIN_LEN)) && (len_o <= LEN_W'(MAX_LEN)));

  a_r3_max_then_min: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && len_o == LEN_W'(MAX_LEN)) |=> (len_o == LEN_W'(MIN_LEN)));
endmodule

// File: rtl/wtg_addr_gen.sv
// Window-bounded address walker with wrap to base.
module wtg_addr_gen #(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
  parameter int                REGION_BYTES = 4096,
  parameter int                BEAT_BYTES   = 8,
  parameter int                LEN_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] issue_addr_o
);
  localparam logic [ADDR_W:0] END_A = {1'b0, BASE_ADDR} + (ADDR_W+1)'(REGION_BYTES);

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W:0]   span;
  logic              fits;

  always_comb begin
    span         = (ADDR_W+1)'(len_i) * (ADDR_W+1)'(BEAT_BYTES);
    fits         = ({1'b0, cur_q} + span) <= END_A;
    issue_addr_o = fits ? cur_q : BASE_ADDR;
    cur_d        = cur_q;
    if (advance_i) cur_d = issue_addr_o + span[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= BASE_ADDR;
    else        cur_q <= cur_d;
  end

  a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_addr_o >= BASE_ADDR) && (({1'b0, issue_addr_o} + span) <= END_A));
endmodule

// File: rtl/axi_wr_traffic_gen.sv
module axi_wr_traffic_gen
  import wtg_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'h0001_0000,
  parameter int                REGION_BYTES = 4096,
  parameter int                MIN_LEN      = 4,
  parameter int                MAX_LEN      = 16,
  parameter int                AVG_LEN      = 8,
  parameter int                GAP_CYCLES   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic                busy_o
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SIZE_CODE  = $clog2(BEAT_BYTES);
  localparam int LEN_W      = 8;
  localparam int HALF       = DATA_W / 2;
  localparam int GAP_CW     = $clog2(GAP_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  wtg_state_e        state_q, state_d;
  logic [LEN_W-1:0]  beat_q, beat_d;
  logic [GAP_CW-1:0] gap_q, gap_d;
  logic [HALF-1:0]   bnum_q, bnum_d;
  logic              run_q, run_d;
  logic              advance;
  logic [LEN_W-1:0]  len;
  logic [ADDR_W-1:0] issue_addr;

  wtg_len_seq #(
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .AVG_LEN(AVG_LEN), .LEN_W(LEN_W)
  ) u_len (
    .clk(clk), .rst_n(rst_sync_n), .advance_i(advance), .len_o(len)
  );

  wtg_addr_gen #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REGION_BYTES(REGION_BYTES),
    .BEAT_BYTES(BEAT_BYTES), .LEN_W(LEN_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .advance_i(advance), .len_i(len),
    .issue_addr_o(issue_addr)
  );

  // channel outputs
  assign m_awvalid = (state_q == ST_ADDR);
  assign m_awaddr  = issue_addr;
  assign m_awlen   = len - 8'd1;
  assign m_awsize  = 3'(SIZE_CODE);
  assign m_awburst = 2'b01;
  assign m_wvalid  = (state_q == ST_DATA);
  assign m_wlast   = m_wvalid && (beat_q == m_awlen);
  assign m_wdata   = {bnum_q, HALF'(beat_q)};
  assign m_wstrb   = '1;
  assign m_bready  = (state_q == ST_RESP);
  assign busy_o    = (state_q != ST_IDLE);
  assign advance   = m_bready && m_bvalid;

  // next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    gap_d   = gap_q;
    bnum_d  = bnum_q;
    run_d   = stop_i ? 1'b0 : (start_i ? 1'b1 : run_q);
    case (state_q)
      ST_IDLE: if (run_q) state_d = ST_ADDR;
      ST_ADDR: if (m_awready) begin
        state_d = ST_DATA;
        beat_d  = '0;
      end
      ST_DATA: if (m_wready) begin
        if (m_wlast) state_d = ST_RESP;
        else         beat_d  = beat_q + 1'b1;
      end
      ST_RESP: if (m_bvalid) begin
        state_d = ST_GAP;
        gap_d   = '0;
        bnum_d  = bnum_q + 1'b1;
      end
      ST_GAP: begin
        if (gap_q == GAP_CW'(GAP_CYCLES - 1)) state_d = run_q ? ST_ADDR : ST_IDLE;
        else                                   gap_d   = gap_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      gap_q   <= '0;
      bnum_q  <= '0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      gap_q   <= gap_d;
      bnum_q  <= bnum_d;
      run_q   <= run_d;
    end
  end

  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));

  a_r10_w_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

  a_r6_one_phase: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({m_awvalid, m_wvalid, m_bready}));

  a_r6_resp_follows_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_wvalid && m_wready && m_wlast) |=> (m_bready && !m_wvalid));

  a_r5_more_beats: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_wvalid && m_wready && !m_wlast) |=> m_wvalid);

  a_r7_quiet_after_resp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_bready && m_bvalid) |=> (!m_awvalid && !m_wvalid && !m_bready));

  a_r9_stop_priority: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: tb/sim_axi_wr_traffic_gen.sv
module sim_axi_wr_traffic_gen;
  localparam int GAP = 5;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  beats;
    logic [3:0]  aw_wait;
    logic        w_stall;
    logic [3:0]  b_wait;
  } vec_t;

  // expected addresses with a 320-byte window at 0x1000, lengths 4,16,4,8
  localparam vec_t VEC [0:9] = '{
    '{32'h1000, 8'd4,  4'd0, 1'b0, 4'd0},
    '{32'h1020, 8'd16, 4'd2, 1'b1, 4'd1},
    '{32'h10A0, 8'd4,  4'd1, 1'b0, 4'd3},
    '{32'h10C0, 8'd8,  4'd0, 1'b1, 4'd0},
    '{32'h1100, 8'd4,  4'd3, 1'b0, 4'd2},
    '{32'h1000, 8'd16, 4'd0, 1'b0, 4'd0},
    '{32'h1080, 8'd4,  4'd1, 1'b1, 4'd1},
    '{32'h10A0, 8'd8,  4'd0, 1'b0, 4'd4},
    '{32'h10E0, 8'd4,  4'd2, 1'b1, 4'd0},
    '{32'h1000, 8'd16, 4'd0, 1'b0, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid, awready = 1'b0;
  logic [63:0] wdata;
  logic [7:0]  wstrb;
  logic        wlast, wvalid, wready = 1'b0;
  logic        bvalid = 1'b0, bready, busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  axi_wr_traffic_gen #(
    .ADDR_W(32), .DATA_W(64), .BASE_ADDR(32'h1000), .REGION_BYTES(320),
    .MIN_LEN(4), .MAX_LEN(16), .AVG_LEN(8), .GAP_CYCLES(GAP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .m_awaddr(awaddr), .m_awlen(awlen), .m_awsize(awsize), .m_awburst(awburst),
    .m_awvalid(awvalid), .m_awready(awready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_wvalid(wvalid),
    .m_wready(wready), .m_bvalid(bvalid), .m_bready(bready), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_window(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!awvalid && !wvalid && !bready, req, "no traffic", {awvalid, wvalid, bready}, 0);
    end
  endtask

  task automatic do_burst(input int idx, input vec_t v, input bit stop_mid);
    int g = 0;
    while (!awvalid && g < 200) begin @(negedge clk); g++; end
    chk(awvalid, "R2", "awvalid seen", awvalid, 1);
    chk(awaddr == v.addr, "R4", "awaddr", awaddr, v.addr);
    chk(awlen == v.beats - 8'd1, "R3", "awlen", awlen, v.beats - 8'd1);
    chk(awsize == 3'd3 && awburst == 2'd1, "R3", "size/burst", {awsize, awburst}, {3'd3, 2'd1});
    for (int i = 0; i < int'(v.aw_wait); i++) begin
      @(negedge clk);
      chk(awvalid && awaddr == v.addr && !wvalid, "R10", "aw held", {awvalid, awaddr}, {1'b1, v.addr});
    end
    awready = 1'b1;
    @(negedge clk);
    awready = 1'b0;
    for (int b = 0; b < int'(v.beats); b++) begin
      if (v.w_stall) begin
        @(negedge clk);
        chk(wvalid && wdata[31:0] == 32'(b), "R10", "w held", wdata, {idx[31:0], b[31:0]});
      end
      chk(wvalid && !awvalid, "R6", "wvalid after aw", {wvalid, awvalid}, 2'b10);
      chk(wdata == {idx[31:0], b[31:0]}, "R5", "wdata", wdata, {idx[31:0], b[31:0]});
      chk(wlast == (b == int'(v.beats) - 1), "R5", "wlast", wlast, (b == int'(v.beats) - 1));
      chk(wstrb == 8'hFF, "R5", "wstrb", wstrb, 8'hFF);
      wready = 1'b1;
      if (stop_mid && b == 1) stop_i = 1'b1;
      @(negedge clk);
      wready = 1'b0;
      stop_i = 1'b0;
    end
    chk(bready && !wvalid, "R6", "bready after last", {bready, wvalid}, 2'b10);
    for (int i = 0; i < int'(v.b_wait); i++) begin
      @(negedge clk);
      chk(bready && !awvalid, "R6", "no aw before resp", {bready, awvalid}, 2'b10);
    end
    bvalid = 1'b1;
    @(negedge clk);
    bvalid = 1'b0;
    if (!stop_mid) begin
      g = 0;
      while (!awvalid && g < 50) begin
        chk(!wvalid && !bready, "R7", "gap quiet", {wvalid, bready}, 0);
        g++;
        @(negedge clk);
      end
      chk(g == GAP, "R7", "gap length", g, GAP);
    end else begin
      for (int i = 0; i < GAP; i++) begin
        chk(busy && !awvalid, "R8", "gap after stop", {busy, awvalid}, 2'b10);
        @(negedge clk);
      end
      chk(!busy, "R8", "idle after stop", busy, 0);
      idle_window(20, "R8");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!awvalid && !wvalid && !bready && !busy, "R1", "in reset",
        {awvalid, wvalid, bready, busy}, 0);
    rst_n = 1'b1;
    idle_window(10, "R1");
    chk(!busy, "R1", "busy before start", busy, 0);

    // start pulse: awvalid two edges later
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!awvalid, "R2", "awvalid one edge after start", awvalid, 0);
    @(negedge clk);
    chk(awvalid, "R2", "awvalid two edges after start", awvalid, 1);

    // table walk, stop issued inside the last burst
    for (int k = 0; k < 10; k++) do_burst(k, VEC[k], k == 9);

    // stop beats start when both arrive together
    start_i = 1'b1;
    stop_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    stop_i  = 1'b0;
    idle_window(15, "R9");
    chk(!busy, "R9", "still idle", busy, 0);

    // restart resumes sequence: phase 2 (4 beats), address 0x1080
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    do_burst(10, '{32'h1080, 8'd4, 4'd0, 1'b0, 4'd0}, 1'b0);
    chk(awaddr == 32'h10A0 && awlen == 8'd7, "R8", "resumed next burst",
        {awaddr, awlen}, {32'h10A0, 8'd7});

    // reset mid-traffic returns to the idle state
    rst_n = 1'b0;
    @(negedge clk);
    chk(!awvalid && !busy, "R1", "reset mid-run", {awvalid, busy}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule